// File: doc/BRIEF.md
# Single-Channel PWM Timer with Start Polarity

This block generates one pulse-width modulated waveform from an 8-bit counter, a period value and a duty value. The counter advances only on a clock-enable strobe from an external prescaler. It runs either edge-aligned (count up, wrap) or center-aligned (count up to the period, then back down). A per-channel polarity input sets the level each period begins with. The output flips to the opposite level once the counter reaches the duty value.

Period and duty writes land in holding registers. They reach the compare logic only at a period boundary, when the counter is written, or at once while the channel is off. Raising the enable input arms the channel, but the counter first moves on the next prescaler strobe, so the first partial period may be irregular. While the enable input is low the pin carries a general-purpose port data bit instead of the waveform. The pin is driven from a flip-flop.

Top module: `pwm_chan`

## Requirements
- R1: In edge-aligned mode (`center_mode`=0) with period P>0, the count runs 0,1,…,P−1,0 on successive strobes. The waveform is the start level while count < duty and the opposite level otherwise.
- R2: In center-aligned mode (`center_mode`=1) with P>0, the count runs 0 up to P and then back down to 1 before returning to 0, so one period lasts 2×P strobes. The same count-below-duty rule sets the level.
- R3: The start level equals `start_high` (1 = each period begins high, 0 = begins low). The opposite level is its inverse.
- R4: Duty 0 gives the opposite level for the whole period. Duty ≥ period gives the start level throughout. Period 0 holds the count at 0 and the waveform at the start level.
- R5: While enabled and running, the count does not change on cycles without a `tick` strobe and without a counter write.
- R6: After `en` rises, the count stays at 0 until the first `tick`. That strobe begins the first period at count 0, and the following strobe moves the count to 1.
- R7: Period and duty writes made while running take effect only when the count returns to 0 at the end of the current period.
- R8: While `en` is 0 the pin follows `port_data`, and period/duty writes are copied to the active values at once.
- R9: A pulse on `cnt_wr` clears the count to 0 and loads the active period and duty from the holding registers, including values written in the same cycle. Counting then resumes on the next strobe.
- R10: The pin is registered. It reads 0 during reset and reflects a change in `en`, `port_data` or the count one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaler clock-enable strobe, one clock wide |
| en | input | 1 | Channel enable |
| start_high | input | 1 | Start polarity: 1 begins each period high |
| center_mode | input | 1 | 1 = up/down counting, 0 = up counting with wrap |
| per_wr | input | 1 | Write strobe for the period holding register |
| per_wdata | input | 8 | Period write data |
| dty_wr | input | 1 | Write strobe for the duty holding register |
| dty_wdata | input | 8 | Duty write data |
| cnt_wr | input | 1 | Counter write strobe: clear and reload |
| port_data | input | 1 | General-purpose data shown on the pin while disabled |
| pwm_pin | output | 1 | Pin output |

## Verification
Most of the checking is a sweep. Every period from 0 to 5 is paired with every duty from 0 to one above the period, in both counting modes and both polarities, over two full periods after enabling. This separates the wrap point of the edge-aligned count from the turn points of the center-aligned count, and it covers the duty-0, duty-at-period and period-0 limits. A duty write in mid-period shows whether the holding register is bypassed too early. A combined period, duty and counter write shows that values written in the same cycle are picked up at once. Idle stretches with no strobe, and port-data toggles while disabled, show that nothing advances without a strobe and that the pin reverts to port data.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         per_wr,
  input  logic [W-1:0] per_wdata,
  input  logic         dty_wr,
  input  logic [W-1:0] dty_wdata,
  input  logic         reload,
  output logic [W-1:0] per_act,
  output logic [W-1:0] dty_act
);
  logic [W-1:0] per_hold, dty_hold, per_hold_nxt, dty_hold_nxt;

  always_comb begin
    per_hold_nxt = per_wr ? per_wdata : per_hold;
    dty_hold_nxt = dty_wr ? dty_wdata : dty_hold;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_hold <= '0;
      dty_hold <= '0;
      per_act  <= '0;
      dty_act  <= '0;
    end else begin
      per_hold <= per_hold_nxt;
      dty_hold <= dty_hold_nxt;
      if (reload) begin
        per_act <= per_hold_nxt;
        dty_act <= dty_hold_nxt;
      end
    end
  end

  // R7
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> ($stable(per_act) && $stable(dty_act)));
endmodule

// File: rtl/pwm_count.sv
module pwm_count
  import pwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic         center_mode,
  input  logic         cnt_wr,
  input  logic [W-1:0] per_act,
  output logic [W-1:0] cnt,
  output logic         reload
);
  logic         run_q;
  dir_e         dir_q, dir_step;
  logic [W-1:0] cnt_step;

  always_comb begin
    cnt_step = '0;
    dir_step = DIR_UP;
    if (per_act == '0) begin
      cnt_step = '0;
    end else if (!center_mode) begin
      cnt_step = (cnt >= per_act - 1'b1) ? '0 : cnt + 1'b1;
    end else if (dir_q == DIR_UP && cnt < per_act) begin
      cnt_step = cnt + 1'b1;
    end else begin
      cnt_step = (cnt == '0) ? '0 : cnt - 1'b1;
      dir_step = (cnt <= 1) ? DIR_UP : DIR_DOWN;
    end
  end

  assign reload = !run_q || !en || cnt_wr || (tick && cnt_step == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt   <= '0;
      dir_q <= DIR_UP;
    end else begin
      run_q <= en && (run_q || tick);
      if (!run_q || !en || cnt_wr) begin
        cnt   <= '0;
        dir_q <= DIR_UP;
      end else if (tick) begin
        cnt   <= cnt_step;
        dir_q <= dir_step;
      end
    end
  end

  // R5
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && en && !tick && !cnt_wr) |=> $stable(cnt));
  // R6
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (cnt == '0));
  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt <= per_act));
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         start_high,
  input  logic         port_data,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] per_act,
  input  logic [W-1:0] dty_act,
  output logic         pin_q
);
  logic level;

  always_comb begin
    if (dty_act >= per_act) level = start_high;
    else if (cnt < dty_act) level = start_high;
    else                    level = !start_high;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= en ? level : port_data;
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         en,
  input  logic         start_high,
  input  logic         center_mode,
  input  logic         per_wr,
  input  logic [W-1:0] per_wdata,
  input  logic         dty_wr,
  input  logic [W-1:0] dty_wdata,
  input  logic         cnt_wr,
  input  logic         port_data,
  output logic         pwm_pin
);
  logic [W-1:0] per_act, dty_act, cnt;
  logic         reload;

  pwm_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .per_wr(per_wr), .per_wdata(per_wdata),
    .dty_wr(dty_wr), .dty_wdata(dty_wdata),
    .reload(reload), .per_act(per_act), .dty_act(dty_act)
  );

  pwm_count #(.W(W)) u_count (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
    .center_mode(center_mode), .cnt_wr(cnt_wr),
    .per_act(per_act), .cnt(cnt), .reload(reload)
  );

  pwm_wave #(.W(W)) u_wave (
    .clk(clk), .rst_n(rst_n), .en(en), .start_high(start_high),
    .port_data(port_data), .cnt(cnt), .per_act(per_act),
    .dty_act(dty_act), .pin_q(pwm_pin)
  );

  // R8
  port_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pwm_pin == $past(port_data)));
  // R4
  per_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && per_act == '0) |=> (pwm_pin == $past(start_high)));
endmodule

// File: tb/pwm_chan_bench.sv
module pwm_chan_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, en = 1'b0, start_high = 1'b0, center_mode = 1'b0;
  logic       per_wr = 1'b0, dty_wr = 1'b0, cnt_wr = 1'b0, port_data = 1'b0;
  logic [7:0] per_wdata = '0, dty_wdata = '0;
  logic       pwm_pin;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  pwm_chan u_pwm_chan (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .start_high(start_high),
    .center_mode(center_mode), .per_wr(per_wr), .per_wdata(per_wdata),
    .dty_wr(dty_wr), .dty_wdata(dty_wdata), .cnt_wr(cnt_wr),
    .port_data(port_data), .pwm_pin(pwm_pin)
  );

  task automatic check(input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: pin=%b expected=%b", what, got, exp);
    end
  endtask

  function automatic logic lvl(int per, int dty, int c, logic pol);
    if (dty >= per) return pol;
    return (c < dty) ? pol : ~pol;
  endfunction

  function automatic int cnt_at(int k, int per, bit ctr);
    int p;
    if (per == 0) return 0;
    if (!ctr) return k % per;
    p = k % (2 * per);
    return (p <= per) ? p : 2 * per - p;
  endfunction

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one strobe, then settle two more clocks; samples land at a negedge
  task automatic strobe();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    clks(2);
  endtask

  task automatic wr_regs(input int per, input int dty, input bit with_cnt);
    @(negedge clk);
    per_wr = 1'b1; per_wdata = 8'(per);
    dty_wr = 1'b1; dty_wdata = 8'(dty);
    cnt_wr = with_cnt;
    @(negedge clk);
    per_wr = 1'b0; dty_wr = 1'b0; cnt_wr = 1'b0;
  endtask

  task automatic run_cfg(input int per, input int dty, input bit ctr, input logic pol);
    string tag;
    int    len;
    en = 1'b0;
    port_data = ~pol;
    wr_regs(per, dty, 1'b0);
    start_high = pol;
    center_mode = ctr;
    clks(2);
    check(pwm_pin, ~pol, "R8 disabled pin shows port data");
    @(negedge clk) en = 1'b1;
    clks(4);
    // R6: no strobe yet, count still 0
    check(pwm_pin, lvl(per, dty, 0, pol), "R6 armed before first strobe");
    if (dty == 0 || dty >= per) tag = "R4";
    else if (ctr) tag = "R2";
    else tag = "R1";
    len = (per == 0) ? 4 : (ctr ? 4 * per : 2 * per) + 1;
    for (int k = 0; k < len; k++) begin
      strobe();
      check(pwm_pin, lvl(per, dty, cnt_at(k, per, ctr), pol),
            $sformatf("%s/R3 per=%0d dty=%0d ctr=%0d pol=%0d k=%0d",
                      tag, per, dty, ctr, pol, k));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: done=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    port_data = 1'b1;
    clks(2);
    check(pwm_pin, 1'b0, "R10 pin low in reset");
    @(negedge clk) rst_n = 1'b1;
    clks(2);
    check(pwm_pin, 1'b1, "R8 pin follows port data after reset");

    // R8/R10: port data toggles while disabled, one-clock latency
    for (int i = 0; i < 4; i++) begin
      @(negedge clk) port_data = ~port_data;
      check(pwm_pin, ~port_data, "R10 pin not yet updated");
      @(negedge clk);
      check(pwm_pin, port_data, "R8 pin follows port data");
    end

    // main sweep
    for (int per = 0; per <= 5; per++)
      for (int dty = 0; dty <= per + 1; dty++)
        for (int ctr = 0; ctr < 2; ctr++)
          for (int pol = 0; pol < 2; pol++)
            run_cfg(per, dty, ctr[0], pol[0]);

    // R7: duty write mid-period waits for the period end
    en = 1'b0; port_data = 1'b0;
    wr_regs(4, 2, 1'b0);
    start_high = 1'b1; center_mode = 1'b0;
    @(negedge clk) en = 1'b1;
    strobe();
    strobe();
    clks(8);
    check(pwm_pin, 1'b1, "R5 no strobe no advance (count 1)");
    @(negedge clk) begin dty_wr = 1'b1; dty_wdata = 8'd3; end
    @(negedge clk) dty_wr = 1'b0;
    strobe();
    check(pwm_pin, 1'b0, "R7 old duty kept at count 2");
    strobe();
    check(pwm_pin, 1'b0, "R7 old duty kept at count 3");
    strobe();
    check(pwm_pin, 1'b1, "R7 new period count 0");
    strobe();
    strobe();
    check(pwm_pin, 1'b1, "R7 new duty used at count 2");
    strobe();
    check(pwm_pin, 1'b0, "R7 new duty count 3");

    // R9: counter write clears and reloads
    en = 1'b0;
    wr_regs(4, 2, 1'b0);
    @(negedge clk) en = 1'b1;
    strobe(); strobe(); strobe();
    check(pwm_pin, 1'b0, "R1 count 2 before counter write");
    wr_regs(6, 5, 1'b1);
    clks(1);
    check(pwm_pin, 1'b1, "R9 count cleared by write");
    for (int j = 1; j <= 7; j++) begin
      strobe();
      check(pwm_pin, ((j % 6) < 5) ? 1'b1 : 1'b0,
            $sformatf("R9 reloaded period 6 duty 5 step %0d", j));
    end

    // R10: disabling returns the pin to port data one clock later
    @(negedge clk) begin port_data = 1'b0; en = 1'b0; end
    check(pwm_pin, 1'b1, "R10 pin holds before edge");
    @(negedge clk);
    check(pwm_pin, 1'b0, "R8 pin back to port data");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule